// File: doc/BRIEF.md
# Hot-Plug Source Selection Controller

This block decides whether a display sink counts as attached. It combines three inputs: a hot-plug pin that is already debounced but not yet synchronous, a hot-plug flag that a link-management protocol produces in this clock domain, and a flag that reports clock-line pull-ups in the sink. From them it forms one effective hot-plug level and raises two sticky interrupts. It also gates writes to a small bank of protected configuration registers, clears that bank when the sink goes away, and reports when power-up is worthwhile.

Software drives the block through a write port and a combinational read port. The control register holds a 2-bit source selector, an enable for the protocol flag and a power-down bit. A mask register and a write-1-to-clear pending register serve the interrupts. A read-only level register shows the synchronized pin, monitor sense and the effective level. The protected registers follow, starting at address 4.

Top module: `hpd_source_ctrl`

## Requirements
- R1: Control register (address 0) bits [1:0] pick the source of the effective level `hpd_eff_o`: 00 = synchronized pin AND gated protocol flag, 01 = gated protocol flag only, 10 = synchronized pin only, 11 = always high.
- R2: The protocol flag counts as low unless control bit 2 is set.
- R3: The pin passes through a two-flop synchronizer. A pin change becomes visible on `hpd_eff_o` after the second rising clock edge.
- R4: Pending bit 0 (address 2) is set one edge after any change of the hot-plug interrupt source. It stays set until a write of 1 to that bit, and a same-cycle set wins over the clear.
- R5: With selector 11 the effective level stays high, while the hot-plug interrupt source is the synchronized pin rather than the effective level.
- R6: Pending bit 1 is set one edge after a rising edge of `msense_i` only. A falling edge does not set it.
- R7: `irq_o` is the OR of the pending bits ANDed with mask register bits (address 1, 1 = enabled). The mask resets to 0.
- R8: While the effective level is low, writes to the protected registers (addresses 4 to 7) leave them unchanged, and `wr_block_o` is high.
- R9: A high-to-low change of the effective level pulses `prot_clr_o` for that cycle. At the next edge the protected registers return to 0, and this clear takes priority over a write.
- R10: Control bit 3 (power-down, output `pwr_down_o`) resets to 1 and can always be set. A write of 0 takes effect only if, before the write, the effective level is high or the selector is 11.
- R11: Level register (address 3) reads bit 0 = synchronized pin, bit 1 = `msense_i`, bit 2 = effective level.
- R12: `pwr_ready_o` is high only while the effective level and `msense_i` are both high.
- R13: After reset the control register reads 0x0A, and the mask, pending and protected registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_pin_i | input | 1 | Debounced hot-plug pin, asynchronous |
| proto_hpd_i | input | 1 | Protocol-derived hot-plug flag, synchronous |
| msense_i | input | 1 | Monitor-sense flag, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| hpd_eff_o | output | 1 | Effective hot-plug level |
| irq_o | output | 1 | Combined interrupt |
| pwr_down_o | output | 1 | Power-down control |
| pwr_ready_o | output | 1 | Sink attached and sensing |
| wr_block_o | output | 1 | Protected writes are blocked |
| prot_clr_o | output | 1 | Protected bank clear pulse |

## Verification
The assertions assume that `proto_hpd_i` and `msense_i` are already synchronous to `clk`, and that a pin level lasts for at least a few cycles, so each change reaches the effective level through the synchronizer. The bench changes every input on the falling edge. It holds each pin level for three cycles or more before it checks, and it changes the selector only at steady levels, so the interrupt source never switches in the same cycle as a pin edge.

// File: rtl/hpd_ctrl_pkg.sv
package hpd_ctrl_pkg;

  typedef enum logic [1:0] {
    SRC_BOTH  = 2'b00,
    SRC_PROTO = 2'b01,
    SRC_PIN   = 2'b10,
    SRC_FORCE = 2'b11
  } hpd_src_e;

  typedef struct packed {
    logic     pwr_down;
    logic     proto_en;
    hpd_src_e sel;
  } ctrl_t;

  localparam int unsigned ADR_CTRL  = 0;
  localparam int unsigned ADR_MASK  = 1;
  localparam int unsigned ADR_PEND  = 2;
  localparam int unsigned ADR_LEVEL = 3;
  localparam int unsigned NUM_IRQ   = 2;

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_select.sv
module hpd_select
  import hpd_ctrl_pkg::*;
(
  input  hpd_src_e sel_i,
  input  logic     proto_en_i,
  input  logic     pin_i,
  input  logic     proto_i,
  output logic     eff_o,
  output logic     irq_src_o
);
  logic proto_gated;

  assign proto_gated = proto_i & proto_en_i;

  always_comb begin
    unique case (sel_i)
      SRC_BOTH:  eff_o = pin_i & proto_gated;
      SRC_PROTO: eff_o = proto_gated;
      SRC_PIN:   eff_o = pin_i;
      default:   eff_o = 1'b1;
    endcase
  end

  assign irq_src_o = (sel_i == SRC_FORCE) ? pin_i : eff_o;
endmodule

// File: rtl/hpd_irq.sv
module hpd_irq #(
  parameter int unsigned          N         = 2,
  parameter logic [N-1:0]         RISE_ONLY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] evt;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (RISE_ONLY[i]) begin : g_rise
      assign evt[i] = lvl_i[i] & ~prev_q[i];
    end else begin : g_any
      assign evt[i] = lvl_i[i] ^ prev_q[i];
    end

    always_comb begin
      pend_d[i] = pend_q[i];
      if (clr_i[i]) pend_d[i] = 1'b0;
      if (evt[i])   pend_d[i] = 1'b1;
    end

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    // R4
    event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i[i] != prev_q[i] && !RISE_ONLY[i]) |=> pend_q[i]);
    // R6
    rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i[i] && !prev_q[i]) |=> pend_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & mask_i);
endmodule

// File: rtl/hpd_cfg_bank.sv
module hpd_cfg_bank
  import hpd_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned PROT_BASE = 4,
  parameter int unsigned NUM_PROT  = 4,
  parameter logic [DATA_W-1:0] PROT_DEF = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       eff_i,
  input  logic                       fall_i,
  output ctrl_t                      ctrl_o,
  output logic [NUM_IRQ-1:0]         mask_o,
  output logic [NUM_IRQ-1:0]         w1c_o,
  output logic [NUM_PROT*DATA_W-1:0] prot_o,
  output logic                       wr_block_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADR_PEND);

  ctrl_t              ctrl_q, ctrl_d;
  logic               ctrl_we;
  logic               pd_allow;
  logic [NUM_IRQ-1:0] mask_q;
  logic               mask_we;

  assign ctrl_we  = wr_en_i && (wr_addr_i == A_CTRL);
  assign mask_we  = wr_en_i && (wr_addr_i == A_MASK);
  assign pd_allow = eff_i || (ctrl_q.sel == SRC_FORCE);

  always_comb begin
    ctrl_d          = ctrl_q;
    ctrl_d.sel      = hpd_src_e'(wr_data_i[1:0]);
    ctrl_d.proto_en = wr_data_i[2];
    if (wr_data_i[3] || pd_allow) ctrl_d.pwr_down = wr_data_i[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.pwr_down <= 1'b1;
      ctrl_q.proto_en <= 1'b0;
      ctrl_q.sel      <= SRC_PIN;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wr_data_i[NUM_IRQ-1:0];
  end

  // R10
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wr_data_i[3] && !pd_allow && ctrl_q.pwr_down) |=> ctrl_q.pwr_down);

  assign w1c_o      = (wr_en_i && wr_addr_i == A_PEND) ? wr_data_i[NUM_IRQ-1:0] : '0;
  assign wr_block_o = ~eff_i;
  assign ctrl_o     = ctrl_q;
  assign mask_o     = mask_q;

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_prot
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PROT_BASE + i);
    logic [DATA_W-1:0] val_q, val_d;
    logic              hit, we;

    assign hit = wr_en_i && (wr_addr_i == MY_ADDR);
    assign we  = fall_i || (hit && eff_i);

    always_comb begin
      val_d = wr_data_i;
      if (fall_i) val_d = PROT_DEF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= PROT_DEF;
      else if (we) val_q <= val_d;
    end

    assign prot_o[i*DATA_W +: DATA_W] = val_q;

    // R8
    blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !eff_i && !fall_i) |=> $stable(val_q));
    // R9
    clr_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_i |=> (val_q == PROT_DEF));
  end
endmodule

// File: rtl/hpd_source_ctrl.sv
module hpd_source_ctrl
  import hpd_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PROT_BASE   = 4,
  parameter int unsigned NUM_PROT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpd_pin_i,
  input  logic              proto_hpd_i,
  input  logic              msense_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hpd_eff_o,
  output logic              irq_o,
  output logic              pwr_down_o,
  output logic              pwr_ready_o,
  output logic              wr_block_o,
  output logic              prot_clr_o
);
  localparam logic [NUM_IRQ-1:0] RISE_MAP = 2'b10;

  logic                       pin_sync;
  logic                       eff;
  logic                       irq_src;
  logic                       eff_q;
  logic                       fall;
  ctrl_t                      ctrl;
  logic [NUM_IRQ-1:0]         mask;
  logic [NUM_IRQ-1:0]         w1c;
  logic [NUM_IRQ-1:0]         pend;
  logic [NUM_PROT*DATA_W-1:0] prot;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(hpd_pin_i), .q_o(pin_sync)
  );

  hpd_select u_sel (
    .sel_i(ctrl.sel), .proto_en_i(ctrl.proto_en), .pin_i(pin_sync),
    .proto_i(proto_hpd_i), .eff_o(eff), .irq_src_o(irq_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= 1'b0;
    else        eff_q <= eff;
  end

  assign fall = eff_q & ~eff;

  hpd_cfg_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PROT_BASE(PROT_BASE), .NUM_PROT(NUM_PROT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .eff_i(eff), .fall_i(fall), .ctrl_o(ctrl),
    .mask_o(mask), .w1c_o(w1c), .prot_o(prot), .wr_block_o(wr_block_o)
  );

  hpd_irq #(.N(NUM_IRQ), .RISE_ONLY(RISE_MAP)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_i({msense_i, irq_src}), .clr_i(w1c),
    .mask_i(mask), .pend_o(pend), .irq_o(irq_o)
  );

  // R9
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_clr_o |=> !prot_clr_o);
  // R5
  force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.sel == SRC_FORCE && $stable(ctrl.sel)) |-> !prot_clr_o);

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADR_CTRL))
      rd_data_o = DATA_W'(ctrl);
    else if (rd_addr_i == ADDR_W'(ADR_MASK))
      rd_data_o = DATA_W'(mask);
    else if (rd_addr_i == ADDR_W'(ADR_PEND))
      rd_data_o = DATA_W'(pend);
    else if (rd_addr_i == ADDR_W'(ADR_LEVEL))
      rd_data_o = DATA_W'({eff, msense_i, pin_sync});
    else
      for (int i = 0; i < NUM_PROT; i++)
        if (rd_addr_i == ADDR_W'(PROT_BASE + i)) rd_data_o = prot[i*DATA_W +: DATA_W];
  end

  assign hpd_eff_o   = eff;
  assign pwr_down_o  = ctrl.pwr_down;
  assign pwr_ready_o = eff & msense_i;
  assign prot_clr_o  = fall;
endmodule

// File: tb/sim_hpd_source_ctrl.sv
`timescale 1ns/1ps
module sim_hpd_source_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin, proto, ms, wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       eff, irq, pd, ready, blk, clr;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  hpd_source_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hpd_pin_i(pin), .proto_hpd_i(proto), .msense_i(ms),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .hpd_eff_o(eff), .irq_o(irq), .pwr_down_o(pd),
    .pwr_ready_o(ready), .wr_block_o(blk), .prot_clr_o(clr)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R13 ctrl", v, 8'h0A);
    rd(1, v); chk("R13 mask", v, 8'h00);
    rd(2, v); chk("R13 pend", v, 8'h00);
    rd(4, v); chk("R13 prot", v, 8'h00);
    chk("R10 pd reset", pd, 1'b1);
    chk("R7 irq reset", irq, 1'b0);
    chk("R12 ready reset", ready, 1'b0);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    pin = 1'b1;
    tick(1); chk("R3 one edge", eff, 1'b0);
    tick(1); chk("R3 two edges", eff, 1'b1);
    rd(3, v); chk("R11 pin level", v[0], 1'b1);
    rd(2, v); chk("R4 not yet", v[0], 1'b0);
    tick(1); rd(2, v); chk("R4 pending", v[0], 1'b1);
    chk("R7 masked", irq, 1'b0);
    wr(1, 8'h01); chk("R7 unmasked", irq, 1'b1);
    tick(2); rd(2, v); chk("R4 sticky", v[0], 1'b1);
    wr(2, 8'h01); rd(2, v); chk("R4 w1c", v[0], 1'b0);
    chk("R7 irq cleared", irq, 1'b0);
  endtask

  task automatic t_select();
    wr(0, 8'h09); chk("R1 sel01 no proto", eff, 1'b0);
    proto = 1'b1; #1; chk("R2 proto disabled", eff, 1'b0);
    wr(0, 8'h0D); chk("R1 sel01 proto", eff, 1'b1);
    wr(0, 8'h0C); chk("R1 sel00 both high", eff, 1'b1);
    proto = 1'b0; #1; chk("R1 sel00 proto low", eff, 1'b0);
    proto = 1'b1;
    wr(0, 8'h08); chk("R2 sel00 disabled", eff, 1'b0);
    proto = 1'b0;
    wr(0, 8'h0A); chk("R1 sel10 pin", eff, 1'b1);
  endtask

  task automatic t_power();
    logic [7:0] v;
    pin = 1'b0; tick(3);
    wr(0, 8'h02); chk("R10 clear blocked", pd, 1'b1);
    rd(0, v); chk("R10 ctrl bit", v[3], 1'b1);
    pin = 1'b1; tick(3);
    wr(0, 8'h02); chk("R10 clear allowed", pd, 1'b0);
    wr(0, 8'h0A); chk("R10 set", pd, 1'b1);
    pin = 1'b0; tick(3);
    wr(0, 8'h0B);
    wr(0, 8'h03); chk("R10 clear in force", pd, 1'b0);
    wr(0, 8'h0B);
  endtask

  task automatic t_force();
    logic [7:0] v;
    wr(2, 8'h03);
    chk("R5 forced high", eff, 1'b1);
    pin = 1'b1;
    tick(2); rd(2, v); chk("R5 not yet", v[0], 1'b0);
    tick(1); rd(2, v); chk("R5 pin rise irq", v[0], 1'b1);
    chk("R5 still high", eff, 1'b1);
    wr(2, 8'h01);
    pin = 1'b0; tick(3); rd(2, v); chk("R5 pin fall irq", v[0], 1'b1);
    chk("R5 high pin low", eff, 1'b1);
    wr(0, 8'h0A); chk("R1 back to pin", eff, 1'b0);
    tick(1); wr(2, 8'h03);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    pin = 1'b1; tick(3);
    wr(4, 8'h5A); rd(4, v); chk("R8 write open", v, 8'h5A);
    chk("R8 block low", blk, 1'b0);
    pin = 1'b0;
    tick(2); chk("R9 clr pulse", clr, 1'b1);
    tick(1); rd(4, v); chk("R9 cleared", v, 8'h00);
    chk("R9 pulse ends", clr, 1'b0);
    chk("R8 block high", blk, 1'b1);
    wr(4, 8'h33); rd(4, v); chk("R8 write ignored", v, 8'h00);
    pin = 1'b1; tick(3);
    wr(5, 8'h77); rd(5, v); chk("R8 write reopens", v, 8'h77);
  endtask

  task automatic t_msense();
    logic [7:0] v;
    wr(2, 8'h03);
    ms = 1'b1; #1; chk("R12 ready", ready, 1'b1);
    tick(1); rd(2, v); chk("R6 rise", v[1], 1'b1);
    rd(3, v); chk("R11 levels", v, 8'h07);
    wr(1, 8'h02); chk("R7 ms irq", irq, 1'b1);
    wr(2, 8'h02); chk("R7 ms cleared", irq, 1'b0);
    ms = 1'b0; tick(2); rd(2, v); chk("R6 fall ignored", v[1], 1'b0);
    chk("R12 not ready", ready, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b0; proto = 1'b0; ms = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    tick(3); rst_n = 1'b1; tick(1);
    t_reset();
    t_sync();
    t_select();
    t_power();
    t_force();
    t_protect();
    t_msense();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule